// File: doc/BRIEF.md
# Cascadable Presettable 4-bit Up-Counter

The block is one stage of a synchronous binary up-counter. Every rising clock edge either clears it, loads a parallel preset word, advances it by one or holds it. The choice is made by a fixed priority: reset first, then load, then count. Counting needs two enables. `gate_en` is a plain advance qualifier. `chain_en` both qualifies the advance and gates the terminal-count output `carry_out`.

Wider counters are built by chaining stages on one clock. Every stage shares `gate_en`, and each higher stage takes its `chain_en` from the `carry_out` of the stage below it. `carry_out` follows `chain_en` combinationally, so the whole carry chain settles within one cycle. The parameter `ASYNC_CLR` picks how the active-low reset acts. With `ASYNC_CLR` = 1 it clears the count as soon as it is asserted. With `ASYNC_CLR` = 0 it clears only at the next rising edge.

None of the ports carries streamed data, so all of them are plain level signals with no handshake.

Top module: `ctr_stage`

## Requirements
- R1: While `rst_n` is low, the count is cleared to 0, whatever the values of `load_n`, `gate_en` and `chain_en`.
- R2: With `ASYNC_CLR` = 1, a low `rst_n` forces the count to 0 immediately, without waiting for a clock edge. With `ASYNC_CLR` = 0, the count keeps its value until the next rising edge and becomes 0 at that edge.
- R3: With `rst_n` high and `load_n` low, a rising edge copies `din` into the count, whatever the enables are.
- R4: With `rst_n` and `load_n` high and both `gate_en` and `chain_en` high, a rising edge adds one to the count.
- R5: With `rst_n` and `load_n` high and either `gate_en` or `chain_en` low, the count keeps its value across the edge.
- R6: `carry_out` is 1 exactly when the count is all ones (15) and `chain_en` is 1. A change on `chain_en` alone changes it within the same cycle.
- R7: Counting up from 15 wraps the count to 0, and `carry_out` falls in that same cycle.
- R8: Two stages chained with a shared clock, a shared `gate_en`, and the low stage's `carry_out` driving the high stage's `chain_en` behave as one 8-bit counter. The high stage advances only on edges where the low stage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on its rising edge |
| rst_n | input | 1 | Active-low clear; async or sync according to `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load of `din` |
| din | input | W | Preset value |
| gate_en | input | 1 | Count enable; does not affect the carry |
| chain_en | input | 1 | Count enable that also gates `carry_out` |
| count | output | W | Current count |
| carry_out | output | 1 | High when the count is all ones and `chain_en` is high |

## Verification
The bench builds two 8-bit chains, one per reset variant, and drives both with the same random mix of reset, load, enable and preset patterns. Directed sequences are added for wrap-through-255, load with the enables low, load while reset is low, and toggling `chain_en` at count 15.

Sampling 1 ns after each input change shows the difference between the two reset variants: the asynchronous chain is already 0, while the synchronous chain still holds its old value. The same sample shows whether the carry follows `chain_en` combinationally. Holds driven with only one enable low show whether the two enables play distinct roles. Wrapping the full 8-bit chain shows whether the carry is correctly ANDed with the lower stage's carry.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_decode.sv
module ctr_decode
  import ctr_pkg::*;
(
  input  logic    rst_n,
  input  logic    load_n,
  input  logic    gate_en,
  input  logic    chain_en,
  output ctr_op_e op
);
  // Fixed priority: clear beats load, and load beats step.
  always_comb begin
    if (!rst_n)                   op = OP_CLEAR;
    else if (!load_n)             op = OP_LOAD;
    else if (gate_en && chain_en) op = OP_STEP;
    else                          op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  ctr_op_e      op,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_STEP:  nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic         chain_en,
  output logic         carry_out
);
  localparam logic [W-1:0] TERMINAL = {W{1'b1}};

  assign carry_out = chain_en && (count == TERMINAL);

  // R6: the carry never rises while the chain enable is low.
  assert_carry_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> chain_en);
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
  import ctr_pkg::*;
#(
  parameter int W        = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         gate_en,
  input  logic         chain_en,
  output logic [W-1:0] count,
  output logic         carry_out
);
  localparam logic [W-1:0] ONE = W'(1);

  ctr_op_e      op;
  logic [W-1:0] nxt;
  logic [W-1:0] cnt_q;

  ctr_decode u_decode (
    .rst_n    (rst_n),
    .load_n   (load_n),
    .gate_en  (gate_en),
    .chain_en (chain_en),
    .op       (op)
  );

  ctr_next #(.W(W)) u_next (
    .cur (cnt_q),
    .din (din),
    .op  (op),
    .nxt (nxt)
  );

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= nxt;
      end
      // R1/R2: the clear is already visible at any edge where reset is held.
      assert_async_clear_R2: assert property (@(posedge clk)
        !rst_n |-> (cnt_q == '0));
    end else begin : g_sync
      always_ff @(posedge clk) cnt_q <= nxt;
      // R1/R2: a sampled reset gives zero one edge later.
      assert_sync_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));
    end
  endgenerate

  assign count = cnt_q;

  ctr_carry #(.W(W)) u_carry (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (cnt_q),
    .chain_en  (chain_en),
    .carry_out (carry_out)
  );

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (count == $past(din)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && gate_en && chain_en) |=> (count == $past(count) + ONE));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(gate_en && chain_en)) |=> $stable(count));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && gate_en && carry_out) |=> (count == '0 && !carry_out));
endmodule

// File: tb/test_ctr_stage.sv
module test_ctr_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] din = '0;
  logic       gate_en = 1'b0;
  logic       chain_en = 1'b0;

  logic [3:0] a_lo, a_hi, s_lo, s_hi;
  logic       a_clo, a_chi, s_clo, s_chi;
  logic [7:0] ref_a, ref_s;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  ctr_stage #(.W(4), .ASYNC_CLR(1'b1)) i_ctr_stage (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din[3:0]),
    .gate_en(gate_en), .chain_en(chain_en), .count(a_lo), .carry_out(a_clo));
  ctr_stage #(.W(4), .ASYNC_CLR(1'b1)) i_ctr_stage_ahi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din[7:4]),
    .gate_en(gate_en), .chain_en(a_clo), .count(a_hi), .carry_out(a_chi));
  ctr_stage #(.W(4), .ASYNC_CLR(1'b0)) i_ctr_stage_slo (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din[3:0]),
    .gate_en(gate_en), .chain_en(chain_en), .count(s_lo), .carry_out(s_clo));
  ctr_stage #(.W(4), .ASYNC_CLR(1'b0)) i_ctr_stage_shi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din[7:4]),
    .gate_en(gate_en), .chain_en(s_clo), .count(s_hi), .carry_out(s_chi));

  function automatic logic [7:0] model_next(logic [7:0] cur, logic r, logic l,
                                            logic [7:0] d, logic p, logic t);
    if (!r)          return 8'h00;
    else if (!l)     return d;
    else if (p && t) return cur + 8'h01;
    else             return cur;
  endfunction

  function automatic string op_tag(logic [7:0] cur, logic r, logic l, logic p, logic t);
    if (!r)          return "R1";
    else if (!l)     return "R3";
    else if (p && t) return (cur == 8'hFF) ? "R7/R8" : "R4/R8";
    else             return "R5";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    if ($isunknown(exp)) return;
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic r, logic l, logic [7:0] d, logic p, logic t);
    string tg;
    rst_n = r; load_n = l; din = d; gate_en = p; chain_en = t;
    if (!r) ref_a = 8'h00;
    #1;
    // R2: the async chain clears at once, the sync chain waits for the edge
    check("R2 async", {a_hi, a_lo}, ref_a);
    check("R2 sync", {s_hi, s_lo}, ref_s);
    // R6: carry follows chain_en combinationally
    check("R6 lo", {7'd0, a_clo}, {7'd0, (ref_a[3:0] == 4'hF) && t});
    check("R6 hi", {7'd0, a_chi}, {7'd0, (ref_a == 8'hFF) && t});
    if (!$isunknown(ref_s))
      check("R6 sync", {6'd0, s_chi, s_clo},
            {6'd0, (ref_s == 8'hFF) && t, (ref_s[3:0] == 4'hF) && t});
    tg = op_tag(ref_a, r, l, p, t);
    @(posedge clk);
    ref_a = model_next(ref_a, r, l, d, p, t);
    ref_s = model_next(ref_s, r, l, d, p, t);
    @(negedge clk);
    check(tg, {a_hi, a_lo}, ref_a);
    check(tg, {s_hi, s_lo}, ref_s);
  endtask

  initial begin
    ref_a = 8'h00;
    ref_s = 8'hxx;
    @(negedge clk);
    step(0, 1, 8'h00, 1, 1);            // R1 reset state
    step(0, 0, 8'hA5, 1, 1);            // R1 reset beats load
    step(1, 0, 8'hFE, 0, 0);            // R3 load with both enables low
    step(1, 1, 8'h00, 1, 1);            // R4 to 0xFF
    step(1, 1, 8'h00, 1, 0);            // R6 carry gated off by chain_en at 0xFF
    step(1, 1, 8'h00, 0, 1);            // R5 hold with gate_en low, carry high
    step(1, 1, 8'h00, 1, 1);            // R7 wrap 0xFF -> 0x00
    step(1, 0, 8'h0E, 1, 1);            // R3 load
    step(1, 1, 8'h00, 1, 1);            // R4 reach 0x0F
    step(1, 1, 8'h00, 0, 0);            // R5 hold, low carry off
    step(1, 1, 8'h00, 1, 1);            // R8 low wrap advances high stage
    step(1, 1, 8'h00, 1, 1);
    step(0, 1, 8'h00, 1, 1);            // R2 reset mid-count
    for (int i = 0; i < 600; i++) begin
      logic r, l, p, t;
      logic [7:0] d;
      r = ($urandom % 25) != 0;
      l = ($urandom % 9) != 0;
      p = ($urandom % 6) != 0;
      t = ($urandom % 6) != 0;
      d = 8'($urandom);
      step(r, l, d, p, t);
    end
    step(1, 0, 8'hF0, 1, 1);
    for (int i = 0; i < 20; i++) step(1, 1, 8'h00, 1, 1);   // R7/R8 through wrap
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule